// File: doc/BRIEF.md
# SPI Word Memory Engine

This block carries out single 16-bit word reads and writes against two serial memories that share one SPI bus: a read-only NOR flash and a read/write SRAM. Both devices are byte-addressed. The block turns the word address into a byte address by doubling it. It sends a one-byte command and a 24-bit address, then moves two data bytes with the more significant byte first.

A client presents a word address, a device select, a direction and write data with a one-cycle request. The block raises `busy`, drives one chip select low for the whole frame and clocks the bus at half the system clock. It then releases the chip select, waits one SCLK period and pulses `done`. A write aimed at the flash is refused without touching the bus. Requests that arrive while a transfer is under way are dropped.

Top module: `spi_word_mem`

## Requirements
- R1: The 24-bit address sent after the command equals the word address shifted left by one bit (bit 0 zero, upper seven bits zero), most significant bit first.
- R2: A read frame carries command byte 0x03 and a write frame carries command byte 0x02, most significant bit first.
- R3: Words are big-endian: on a write, bits 15:8 go out first and land at the even byte address; on a read, the first byte received becomes `rd_data[15:8]`.
- R4: SCLK runs at half the system clock. It is never high on two consecutive clocks, and every frame has exactly 48 SCLK pulses.
- R5: SPI mode 0 is used. SCLK is low whenever a chip select changes, MOSI only changes while SCLK is low, and MISO is sampled while SCLK is high.
- R6: `req_dev` = 0 selects the flash (`flash_cs_n`) and 1 selects the SRAM (`sram_cs_n`). At most one chip select is low at any time.
- R7: The chip select stays low for the entire frame (96 system clocks). Both chip selects are then high for at least two clocks before `done` pulses.
- R8: In reset and while idle, both chip selects are high, SCLK is low, and `busy` and `done` are low.
- R9: A write request with `req_dev` = 0 produces no bus activity, leaves `rd_data` unchanged, and pulses `done` on the clock after the request.
- R10: A request made while `busy` is high is ignored: no extra frame is sent, and the running frame keeps its own address and command.
- R11: `done` is a one-cycle pulse. `rd_data` updates with `done` after a read and holds its value through later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle access request, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 1 | 0 = flash, 1 = SRAM |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read |
| spi_sclk | output | 1 | Shared serial clock |
| spi_mosi | output | 1 | Shared serial data out |
| spi_miso | input | 1 | Shared serial data in |
| flash_cs_n | output | 1 | Flash chip select, active low |
| sram_cs_n | output | 1 | SRAM chip select, active low |

## Verification
The embedded assertions check the per-cycle bus rules on every clock: the two chip selects are never low together, SCLK is never high twice in a row, MOSI holds steady while SCLK is high, the bus is quiet whenever the block is idle, the flash is never selected for a write, and `done` is a lone pulse preceded by two chip-select-high clocks. Only the bench scenarios can show that whole frames are correct. A behavioural SPI memory on the bus decodes the command and the doubled address and stores the bytes in arrival order, so big-endian order, write-then-read round trips, the refused flash write and the dropped mid-frame request are all judged through the data that comes back.

// File: rtl/spi_word_pkg.sv
// Package: shared constants and state type for the SPI word memory engine.
// Assumes a single-lane SPI bus, mode 0, with 24-bit device addressing.
package spi_word_pkg;
    localparam logic [7:0] CMD_RD = 8'h03;
    localparam logic [7:0] CMD_WR = 8'h02;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_GAP,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/spi_bit_engine.sv
// Bit engine: shifts a fixed-length frame out on MOSI at half the system
// clock in SPI mode 0 and collects the final RX_W bits seen on MISO.
// Assumes the controller holds chip select low while active is high.
module spi_bit_engine #(
    parameter int FRAME_W = 48,
    parameter int RX_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic [RX_W-1:0]    rx_word,
    output logic               last
);
    localparam int CNT_W = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               active_q;
    logic               sclk_q;

    // Final falling edge of the frame.
    assign last = active_q && sclk_q && (cnt_q == CNT_W'(FRAME_W - 1));
    assign sclk = sclk_q;
    assign mosi = sh_q[FRAME_W-1];

    // Clock toggling, shift out on the falling edge, sample during the high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            rx_word  <= '0;
        end else if (start && !active_q) begin
            sh_q     <= frame;
            cnt_q    <= '0;
            active_q <= 1'b1;
            sclk_q   <= 1'b0;
        end else if (active_q) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else begin
                sclk_q  <= 1'b0;
                rx_word <= {rx_word[RX_W-2:0], miso};
                sh_q    <= {sh_q[FRAME_W-2:0], 1'b0};
                cnt_q   <= cnt_q + 1'b1;
                if (last) active_q <= 1'b0;
            end
        end
    end

    AST_SCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_q |=> !sclk_q); // R4
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !sclk_q); // R8
endmodule

// File: rtl/spi_word_ctrl.sv
// Access sequencer: accepts a word request when idle, builds the command,
// address and data frame, drives the chip selects and closes each access
// with a chip-select-high gap followed by a done pulse.
// Assumes the bit engine reports the final falling edge through xfer_last.
module spi_word_ctrl
    import spi_word_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int DEV_AW   = 24,
    parameter int GAP_CLKS = 2,
    localparam int FRAME_W = 8 + DEV_AW + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               req_write,
    input  logic               req_dev,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               xfer_last,
    input  logic [DATA_W-1:0]  rx_word,
    output logic               start,
    output logic [FRAME_W-1:0] frame,
    output logic               flash_cs_n,
    output logic               sram_cs_n,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int GAP_W = $clog2(GAP_CLKS + 1);
    localparam int PAD_W = DEV_AW - ADDR_W - 1;

    seq_state_t       state_q;
    logic [GAP_W-1:0] gap_q;
    logic             wr_q;
    logic             accept;
    logic             refuse;
    logic [DEV_AW-1:0] byte_addr;

    assign accept    = (state_q == ST_IDLE) && req;
    assign refuse    = req_write && !req_dev;
    assign byte_addr = {{PAD_W{1'b0}}, req_addr, 1'b0};
    assign start     = accept && !refuse;
    assign frame     = {(req_write ? CMD_WR : CMD_RD), byte_addr,
                        (req_write ? req_wdata : {DATA_W{1'b0}})};
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_DONE);

    // Access sequencing and chip-select control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            gap_q      <= '0;
            wr_q       <= 1'b0;
            flash_cs_n <= 1'b1;
            sram_cs_n  <= 1'b1;
            rd_data    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    wr_q <= req_write;
                    if (refuse) begin
                        state_q <= ST_DONE;
                    end else begin
                        state_q    <= ST_XFER;
                        flash_cs_n <= req_dev;
                        sram_cs_n  <= !req_dev;
                    end
                end
                ST_XFER: if (xfer_last) begin
                    state_q    <= ST_GAP;
                    flash_cs_n <= 1'b1;
                    sram_cs_n  <= 1'b1;
                    gap_q      <= '0;
                end
                ST_GAP: begin
                    gap_q <= gap_q + 1'b1;
                    if (gap_q == GAP_W'(GAP_CLKS - 1)) begin
                        state_q <= ST_DONE;
                        if (!wr_q) rd_data <= rx_word;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_cs_n && !sram_cs_n)); // R6
    AST_FLASH_RO: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_cs_n |-> !wr_q); // R9
    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |-> (flash_cs_n != sram_cs_n)); // R7
endmodule

// File: rtl/spi_word_mem.sv
// Top: word-oriented access engine for a flash and an SRAM on one SPI bus.
// Assumes the caller decodes which device a word address belongs to.
module spi_word_mem #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int DEV_AW   = 24,
    parameter int GAP_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic              req_dev,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              flash_cs_n,
    output logic              sram_cs_n
);
    localparam int FRAME_W = 8 + DEV_AW + DATA_W;

    logic               start;
    logic               xfer_last;
    logic [FRAME_W-1:0] frame;
    logic [DATA_W-1:0]  rx_word;

    spi_word_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_AW(DEV_AW), .GAP_CLKS(GAP_CLKS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
        .xfer_last(xfer_last), .rx_word(rx_word), .start(start),
        .frame(frame), .flash_cs_n(flash_cs_n), .sram_cs_n(sram_cs_n),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    spi_bit_engine #(
        .FRAME_W(FRAME_W), .RX_W(DATA_W)
    ) u_bits (
        .clk(clk), .rst_n(rst_n), .start(start), .frame(frame),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .rx_word(rx_word), .last(xfer_last)
    );

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_mosi)); // R5
    AST_CS_EDGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(flash_cs_n) || $changed(sram_cs_n)) |-> !spi_sclk); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (flash_cs_n && sram_cs_n && !spi_sclk && !done)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_GAP_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(flash_cs_n && sram_cs_n, 1) && $past(flash_cs_n && sram_cs_n, 2))); // R7
endmodule

// File: tb/spi_word_mem_test.sv
module spi_word_mem_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_write = 1'b0, req_dev = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        busy, done, spi_sclk, spi_mosi, flash_cs_n, sram_cs_n;
    logic        spi_miso = 1'b0;
    logic [15:0] rd_data;

    int checks = 0, fails = 0;

    always #4 clk = ~clk; // 125 MHz

    spi_word_mem uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .flash_cs_n(flash_cs_n),
        .sram_cs_n(sram_cs_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return (a[7:0] * 8'd3) ^ 8'hA5 ^ a[15:8];
    endfunction

    // ---------------- behavioural SPI memory on the bus ----------------
    logic [7:0]  slv_ram [int];
    logic [47:0] s_sh = '0;
    int          s_cnt = 0;
    bit          s_dev = 0;
    logic [15:0] s_rd = '0;
    int          frames = 0, last_bits = 0;
    logic [7:0]  last_cmd = '0;
    logic [23:0] last_addr = '0;
    bit          last_dev = 0;

    function automatic logic [7:0] rget(input int a);
        return slv_ram.exists(a) ? slv_ram[a] : 8'hEE;
    endfunction

    // Samples MOSI on rising SCLK; closes the frame when chip select rises.
    always @(posedge spi_sclk or posedge flash_cs_n or posedge sram_cs_n) begin
        if (flash_cs_n && sram_cs_n) begin
            if (s_cnt > 0) begin
                frames++;
                last_bits = s_cnt;
                if (s_sh[(s_cnt-1) -: 8] == 8'h02 && s_cnt == 48 && s_dev) begin
                    slv_ram[int'(last_addr)]     = s_sh[15:8];
                    slv_ram[int'(last_addr) + 1] = s_sh[7:0];
                end
            end
            s_cnt = 0;
        end else begin
            s_sh  = {s_sh[46:0], spi_mosi};
            s_cnt++;
            s_dev = !sram_cs_n;
            if (s_cnt == 32) begin
                last_cmd  = s_sh[31:24];
                last_addr = s_sh[23:0];
                last_dev  = s_dev;
                s_rd = s_dev ? {rget(int'(s_sh[23:0])), rget(int'(s_sh[23:0]) + 1)}
                             : {fbyte(s_sh[23:0]), fbyte(s_sh[23:0] + 24'd1)};
            end
        end
    end

    // Drives MISO on falling SCLK, high byte first.
    always @(negedge spi_sclk) begin
        if (s_cnt >= 32 && s_cnt < 48) spi_miso = s_rd[47 - s_cnt];
        else spi_miso = 1'b0;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          noop;
        bit          wr;
        bit          dev;
        logic [7:0]  cmd;
        logic [23:0] baddr;
        logic [15:0] rdata;
        int          frames_before;
    } exp_t;
    exp_t sb[$];
    logic [7:0]  ref_ram [int];
    logic [15:0] held_rd = '0;

    int gap_cnt = 0, low_cnt = 0, high_cnt = 0, last_low = 0, last_high = 0;

    // Monitor: compares each completed access, then updates bus cycle counters.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(0, "R11 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.noop) begin
                    chk(frames == e.frames_before, "R9 flash write caused a frame", frames, e.frames_before);
                    chk(rd_data == held_rd, "R9 rd_data changed by refused write", rd_data, held_rd);
                end else begin
                    chk(frames == e.frames_before + 1, "R10 frame count", frames, e.frames_before + 1);
                    chk(last_cmd == e.cmd, "R2 command byte", last_cmd, e.cmd);
                    chk(last_addr == e.baddr, "R1 byte address", last_addr, e.baddr);
                    chk(last_dev == e.dev, "R6 device select", last_dev, e.dev);
                    chk(last_bits == 48 && last_high == 48, "R4 SCLK pulses per frame", last_high, 48);
                    chk(last_low == 96, "R7 chip select low clocks", last_low, 96);
                    chk(gap_cnt >= 2, "R7 gap before done", gap_cnt, 2);
                    if (e.wr) begin
                        chk(rd_data == held_rd, "R11 rd_data held over write", rd_data, held_rd);
                    end else begin
                        chk(rd_data == e.rdata, "R3 read data", rd_data, e.rdata);
                        held_rd = e.rdata;
                    end
                end
            end
        end
        if (flash_cs_n && sram_cs_n) begin
            if (low_cnt > 0) begin
                last_low  = low_cnt;
                last_high = high_cnt;
            end
            low_cnt  = 0;
            high_cnt = 0;
            gap_cnt++;
        end else begin
            gap_cnt = 0;
            low_cnt++;
            if (spi_sclk) high_cnt++;
        end
    end

    // Driver: push the expectation, issue the request, wait for completion.
    task automatic access(input bit dev, input bit wr, input logic [15:0] a,
                          input logic [15:0] wd, input bit poke);
        exp_t e;
        e.noop  = wr && !dev;
        e.wr    = wr;
        e.dev   = dev;
        e.cmd   = wr ? 8'h02 : 8'h03;
        e.baddr = {7'b0, a, 1'b0};
        e.frames_before = frames;
        if (dev) e.rdata = {ref_ram.exists(int'(e.baddr)) ? ref_ram[int'(e.baddr)] : 8'hEE,
                            ref_ram.exists(int'(e.baddr)+1) ? ref_ram[int'(e.baddr)+1] : 8'hEE};
        else     e.rdata = {fbyte(e.baddr), fbyte(e.baddr + 24'd1)};
        if (wr && dev) begin
            ref_ram[int'(e.baddr)]     = wd[15:8];
            ref_ram[int'(e.baddr) + 1] = wd[7:0];
        end
        sb.push_back(e);
        @(negedge clk);
        req = 1'b1; req_write = wr; req_dev = dev; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        if (e.noop) begin
            chk(done == 1'b1, "R9 refused write done latency", done, 1);
            chk(flash_cs_n && sram_cs_n, "R9 no chip select on refused write", {flash_cs_n, sram_cs_n}, 2'b11);
        end else begin
            if (poke) begin
                repeat (20) @(negedge clk);
                chk(busy == 1'b1, "R10 busy during frame", busy, 1);
                req = 1'b1; req_write = 1'b1; req_dev = 1'b1; req_addr = 16'h5555; req_wdata = 16'hDEAD;
                @(negedge clk);
                req = 1'b0;
            end
            while (!done) @(negedge clk);
        end
        @(negedge clk);
        chk(done == 1'b0, "R11 done single pulse", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(flash_cs_n && sram_cs_n, "R8 chip selects high in reset", {flash_cs_n, sram_cs_n}, 2'b11);
        chk(!spi_sclk && !busy && !done, "R8 quiet in reset", {spi_sclk, busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(flash_cs_n && sram_cs_n && !spi_sclk && !busy, "R8 quiet when idle",
            {flash_cs_n, sram_cs_n, spi_sclk, busy}, 4'b1100);

        access(0, 0, 16'h0000, '0, 0);          // R1 R2 R3 flash reads
        access(0, 0, 16'h1234, '0, 0);
        access(0, 0, 16'h7EFF, '0, 0);
        access(1, 1, 16'h8000, 16'hBEEF, 0);    // R3 SRAM write, high byte at even address
        access(1, 0, 16'h8000, '0, 0);
        access(1, 1, 16'hFFFF, 16'h0102, 0);
        access(1, 0, 16'hFFFF, '0, 0);
        access(0, 1, 16'h0040, 16'hAAAA, 0);    // R9 refused flash write
        access(1, 0, 16'hA5A5, '0, 1);          // R10 request during frame dropped
        chk(!slv_ram.exists(32'hAAAA), "R10 dropped write reached memory", 1, 0);
        access(1, 1, 16'h9001, 16'h00FF, 0);    // R11 rd_data held across write
        access(1, 0, 16'h9001, '0, 0);
        chk(slv_ram.exists(32'h12002) && slv_ram[32'h12002] == 8'h00 && slv_ram[32'h12003] == 8'hFF,
            "R3 stored byte order", {slv_ram[32'h12002], slv_ram[32'h12003]}, 16'h00FF);
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R11 every access completed", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule